// File: doc/BRIEF.md
# Sticky Interrupt Latch Controller

This block gathers a set of charger-side alarm conditions (16 by default) and two fuel-gauge alarms into one active-low interrupt request. The request is meant to drive an open-drain pin. Each condition is sampled on every clock. A rising edge records a sticky latch bit. If that source is enabled, the rising edge also raises a pending interrupt that pulls the line low. The host reaches the block through a small register port made of an address, write data, a write strobe and combinational read data. Through that port it programs the enables, reads and clears the latches, and manages the line.

Charger-side interrupts are released together by a two-step handshake: the host writes 0 and then 1 to a release bit. A latch bit is cleared only when the host writes 0 to it and its condition has already gone away. The two gauge alarms share one enable. They hold the line low for as long as either alarm bit is set, and they are released by clearing those bits. A separate force bit lets software pull the line low directly. Reading that bit returns the level the block drives on the line.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset, every source enable and every latch bit is 0, the gauge alarm enable is 1, both gauge alarm bits are 0, the release bit and the force bit are 1, and irq_n is 1.
- R2: A rising edge on a source condition sets that source's latch bit whether or not the source is enabled. The latch bit stays 1 after the condition falls.
- R3: A rising edge on an enabled source drives irq_n low at the first clock edge that samples the new condition level. A rising edge on a masked source leaves irq_n at 1.
- R4: Writing 0 to a latch bit clears it only if that source's condition is low at the write. Writing 1 to a latch bit leaves it unchanged.
- R5: A condition that stays high after its interrupt has been released produces no further interrupt.
- R6: A write of 1 to the release bit (line register bit 0) while the bit holds 0 releases every pending charger-side interrupt. A write of 1 while the bit already holds 1 releases nothing. An enabled rising edge in the same cycle as the release stays pending.
- R7: With the gauge enable set, a rising edge on either gauge condition sets its alarm bit and holds irq_n low until the host writes 0 to that bit. A cleared alarm sets again only after its condition falls and rises again.
- R8: While the gauge enable is 0, rising edges on the gauge conditions set no gauge alarm bit and leave irq_n at 1.
- R9: Writing 0 to the force bit (line register bit 1) drives irq_n low whatever the interrupt state. Writing 1 returns the line to the interrupt logic. Reading bit 1 of the line register returns the current irq_n level.
- R10: irq_n stays low while any charger-side interrupt is pending or any gauge alarm bit is set. Releasing one kind of interrupt does not release the line while the other kind is active.
- R11: Register map with 8-bit data and 16 sources. Addresses 0 and 1 are the enables for sources 7..0 and 15..8. Addresses 2 and 3 are the latches for the same sources, with source k at bit k mod 8. Address 4 is the gauge register: bit 0 is the enable, bit 1 is the low-voltage alarm, bit 2 is the low-charge alarm. Address 5 is the line register: bit 0 is release, bit 1 is force on write and line level on read. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_cond | input | NUM_SRC | Charger-side alarm condition levels |
| gauge_volt_low | input | 1 | Gauge low-voltage condition level |
| gauge_charge_low | input | 1 | Gauge low-charge condition level |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_wdata | input | DATA_W | Register write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| irq_n | output | 1 | Active-low interrupt drive for the open-drain pin |

## Verification
The bench walks every source in turn against an enable pattern that masks every third source. For each source it checks the latch word, the line level, a clear attempt while the condition is still high, the release handshake, and the final clear after the condition falls.

Each corner case targets a specific fault:
- A design that clears a latch regardless of its condition would lose the bit while the alarm is still active.
- A design that re-triggers on level instead of edge would pull the line low again after the release.
- A design that releases on any write of 1 would drop pending interrupts without the 0-then-1 handshake.
- A design that drops a rise arriving in the release cycle would lose that interrupt.

The gauge tests cover disabled alarms, re-firing after a clear, and mixed charger and gauge activity. A design that ORs only one group into the line would float it early.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  // Bit positions inside the gauge register
  localparam int GAUGE_EN_BIT  = 0;
  localparam int GAUGE_VLT_BIT = 1;
  localparam int GAUGE_CHG_BIT = 2;
  // Bit positions inside the line register
  localparam int LINE_REL_BIT  = 0;
  localparam int LINE_FRC_BIT  = 1;

  // Address layout: enable bytes, latch bytes, gauge register, line register
  function automatic int unsigned en_addr(int unsigned b);
    return b;
  endfunction
  function automatic int unsigned lat_addr(int unsigned nb, int unsigned b);
    return nb + b;
  endfunction
  function automatic int unsigned gauge_addr(int unsigned nb);
    return 2 * nb;
  endfunction
  function automatic int unsigned line_addr(int unsigned nb);
    return 2 * nb + 1;
  endfunction
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise
);
  logic [WIDTH-1:0] level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] cond,
  input  logic [NUM_SRC-1:0] rise,
  input  logic [NUM_SRC-1:0] en,
  input  logic [NUM_SRC-1:0] clr_req,
  input  logic               release_evt,
  output logic [NUM_SRC-1:0] latch_q,
  output logic [NUM_SRC-1:0] pend_q
);
  logic [NUM_SRC-1:0] clr_ok;
  logic [NUM_SRC-1:0] new_irq;

  assign clr_ok  = clr_req & ~cond;
  assign new_irq = rise & en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      pend_q  <= '0;
    end else begin
      latch_q <= (latch_q & ~clr_ok) | rise;
      pend_q  <= (release_evt ? '0 : pend_q) | new_irq;
    end
  end

  genvar i;
  generate
    for (i = 0; i < NUM_SRC; i++) begin : g_chk
      assert_rise_latches_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise[i] |=> latch_q[i]);
      assert_active_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q[i] && cond[i]) |=> latch_q[i]);
      assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en[i] |=> !$rose(pend_q[i]));
    end
  endgenerate

  assert_release_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (release_evt && new_irq == '0) |=> pend_q == '0);
endmodule

// File: rtl/irq_gauge_alarm.sv
module irq_gauge_alarm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rise,
  input  logic       en,
  input  logic [1:0] clr_req,
  output logic [1:0] alarm_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alarm_q <= '0;
    else        alarm_q <= (alarm_q & ~clr_req) | (rise & {2{en}});
  end

  assert_disabled_vlt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !$rose(alarm_q[0]));
  assert_disabled_chg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !$rose(alarm_q[1]));
  assert_edge_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise == 2'b00 && clr_req == 2'b00) |=> $stable(alarm_q));
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl #(
  parameter int NUM_SRC = 16,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_cond,
  input  logic               gauge_volt_low,
  input  logic               gauge_charge_low,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic               reg_wr,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq_n
);
  import irq_latch_pkg::*;

  localparam int NB = NUM_SRC / DATA_W;
  localparam logic [ADDR_W-1:0] GAUGE_A = ADDR_W'(gauge_addr(NB));
  localparam logic [ADDR_W-1:0] LINE_A  = ADDR_W'(line_addr(NB));

  logic [NUM_SRC-1:0] en_q, clr_req, src_latch, src_pend, src_rise;
  logic [NUM_SRC+1:0] all_rise;
  logic [1:0]         g_alarm, g_clr;
  logic               g_en_q, rel_q, force_q;
  logic               wr_gauge, wr_line, release_evt;

  irq_edge_detect #(.WIDTH(NUM_SRC + 2)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .level({gauge_charge_low, gauge_volt_low, src_cond}),
    .rise(all_rise)
  );
  assign src_rise = all_rise[NUM_SRC-1:0];

  assign wr_gauge    = reg_wr && (reg_addr == GAUGE_A);
  assign wr_line     = reg_wr && (reg_addr == LINE_A);
  assign release_evt = wr_line && !rel_q && reg_wdata[LINE_REL_BIT];

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_byte
      localparam logic [ADDR_W-1:0] EA = ADDR_W'(en_addr(b));
      localparam logic [ADDR_W-1:0] LA = ADDR_W'(lat_addr(NB, b));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        en_q[b*DATA_W +: DATA_W] <= '0;
        else if (reg_wr && reg_addr == EA) en_q[b*DATA_W +: DATA_W] <= reg_wdata;
      end
      assign clr_req[b*DATA_W +: DATA_W] =
        (reg_wr && reg_addr == LA) ? ~reg_wdata : '0;
    end
  endgenerate

  irq_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .cond(src_cond), .rise(src_rise), .en(en_q),
    .clr_req(clr_req), .release_evt(release_evt),
    .latch_q(src_latch), .pend_q(src_pend)
  );

  assign g_clr = wr_gauge ? ~{reg_wdata[GAUGE_CHG_BIT], reg_wdata[GAUGE_VLT_BIT]} : 2'b00;

  irq_gauge_alarm u_gauge (
    .clk(clk), .rst_n(rst_n), .rise(all_rise[NUM_SRC+1:NUM_SRC]),
    .en(g_en_q), .clr_req(g_clr), .alarm_q(g_alarm)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_en_q  <= 1'b1;
      rel_q   <= 1'b1;
      force_q <= 1'b1;
    end else begin
      if (wr_gauge) g_en_q <= reg_wdata[GAUGE_EN_BIT];
      if (wr_line) begin
        rel_q   <= reg_wdata[LINE_REL_BIT];
        force_q <= reg_wdata[LINE_FRC_BIT];
      end
    end
  end

  assign irq_n = force_q && (src_pend == '0) && (g_alarm == 2'b00);

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NB; k++) begin
      if (reg_addr == ADDR_W'(en_addr(k)))     reg_rdata = en_q[k*DATA_W +: DATA_W];
      if (reg_addr == ADDR_W'(lat_addr(NB, k))) reg_rdata = src_latch[k*DATA_W +: DATA_W];
    end
    if (reg_addr == GAUGE_A) reg_rdata = DATA_W'({g_alarm, g_en_q});
    if (reg_addr == LINE_A)  reg_rdata = DATA_W'({irq_n, rel_q});
  end

  assert_pending_holds_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (src_pend != '0 || g_alarm != 2'b00) |-> !irq_n);
  assert_force_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_line && !reg_wdata[LINE_FRC_BIT]) |=> !irq_n);
  assert_enabled_edge_fires_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_rise & en_q) != '0) |=> !irq_n);
endmodule

// File: tb/test_irq_latch_ctrl.sv
module test_irq_latch_ctrl;
  localparam int N = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src_cond = '0;
  logic gv = 1'b0, gc = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_rdata;
  logic irq_n;
  int checks = 0, errors = 0;
  bit done = 0;

  irq_latch_ctrl i_irq_latch_ctrl (
    .clk(clk), .rst_n(rst_n), .src_cond(src_cond), .gauge_volt_low(gv),
    .gauge_charge_low(gc), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rdata(reg_rdata), .irq_n(irq_n));

  always #5 clk = ~clk;

  function automatic bit en_of(int i);
    return (i % 3) != 0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    reg_addr = 3'(a); reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [7:0] d);
    reg_addr = 3'(a); #1; d = reg_rdata;
  endtask

  task automatic rd_lat(output logic [15:0] w);
    logic [7:0] lo, hi;
    rd(2, lo); rd(3, hi); w = {hi, lo};
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic handshake();
    wr(5, 8'h02); wr(5, 8'h03);
  endtask

  initial begin
    logic [7:0] d;
    logic [15:0] w, enp;
    enp = '0;
    for (int i = 0; i < N; i++) enp[i] = en_of(i);
    step(3); rst_n = 1'b1; step(1);

    // R1 reset state
    rd(0, d); chk("R1 en lo", d, 0);
    rd(1, d); chk("R1 en hi", d, 0);
    rd_lat(w); chk("R1 latch", w, 0);
    rd(4, d); chk("R1 gauge", d, 8'h01);
    rd(5, d); chk("R1 line", d, 8'h03);
    chk("R1 irq", irq_n, 1);

    wr(0, enp[7:0]); wr(1, enp[15:8]);
    rd(0, d); chk("R11 en lo", d, enp[7:0]);
    rd(1, d); chk("R11 en hi", d, enp[15:8]);
    rd(7, d); chk("R11 unmapped", d, 0);

    for (int i = 0; i < N; i++) begin
      int lb;
      lb = 2 + i / 8;
      src_cond[i] = 1'b1; step(1);
      rd_lat(w); chk("R2 set", w, 32'(1 << i));
      chk("R3 line", irq_n, !en_of(i));
      wr(lb, 8'h00);
      rd_lat(w); chk("R4 held", w, 32'(1 << i));
      handshake();
      chk("R6 release", irq_n, 1);
      step(2); chk("R5 no refire", irq_n, 1);
      src_cond[i] = 1'b0; step(1);
      rd_lat(w); chk("R2 sticky", w, 32'(1 << i));
      wr(lb, 8'h00);
      rd_lat(w); chk("R4 cleared", w, 0);
    end

    // R4 writing 1 keeps the bit
    src_cond[5] = 1'b1; step(1); src_cond[5] = 1'b0; step(1);
    wr(2, 8'hFF); rd_lat(w); chk("R4 write1", w, 16'h0020);
    wr(2, 8'h00); handshake();

    // R6 write 1 without preceding 0 does nothing
    src_cond[1] = 1'b1; step(1);
    wr(5, 8'h03); chk("R6 no handshake", irq_n, 0);
    handshake(); chk("R6 handshake", irq_n, 1);
    // R6 rise in the release cycle stays pending
    wr(5, 8'h02);
    src_cond[2] = 1'b1; wr(5, 8'h03);
    chk("R6 same-cycle rise", irq_n, 0);
    src_cond[1] = 1'b0; src_cond[2] = 1'b0; step(1);
    handshake(); chk("R6 after", irq_n, 1);
    wr(2, 8'h00);

    // R7 gauge alarm
    gv = 1'b1; step(1);
    rd(4, d); chk("R7 set", d, 8'h03); chk("R7 line", irq_n, 0);
    wr(4, 8'h01); rd(4, d); chk("R7 cleared", d, 8'h01);
    chk("R7 released", irq_n, 1);
    step(2); chk("R7 no refire", irq_n, 1);
    gv = 1'b0; step(1); gv = 1'b1; step(1);
    rd(4, d); chk("R7 refire", d, 8'h03);
    wr(4, 8'h01); gv = 1'b0; step(1);

    // R10 mixed sources
    gc = 1'b1; src_cond[4] = 1'b1; step(1);
    rd(4, d); chk("R7 charge", d, 8'h05);
    handshake(); chk("R10 gauge holds", irq_n, 0);
    wr(4, 8'h01); chk("R10 free", irq_n, 1);
    gc = 1'b0; src_cond[4] = 1'b0; step(1);
    gc = 1'b1; src_cond[4] = 1'b1; step(1);
    wr(4, 8'h01); chk("R10 charger holds", irq_n, 0);
    handshake(); chk("R10 free2", irq_n, 1);
    gc = 1'b0; src_cond[4] = 1'b0; step(1); wr(2, 8'h00);

    // R8 gauge disabled
    wr(4, 8'h00); gv = 1'b1; gc = 1'b1; step(2);
    rd(4, d); chk("R8 no alarm", d, 8'h00); chk("R8 line", irq_n, 1);
    wr(4, 8'h01); gv = 1'b0; gc = 1'b0; step(1);
    rd(4, d); chk("R8 restored", d, 8'h01);

    // R9 force
    wr(5, 8'h01); chk("R9 forced", irq_n, 0);
    rd(5, d); chk("R9 level low", d[1], 0);
    wr(5, 8'h03); chk("R9 unforced", irq_n, 1);
    rd(5, d); chk("R9 level high", d[1], 1);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule